// File: doc/BRIEF.md
# Fetch Line Cache with Victim Buffer

This block sits on the instruction fetch path. It turns a 32-bit virtual fetch address into a physical byte address. It does this by keeping recently used line translations in a 256-line direct-mapped primary array. A 16-entry fully associative victim buffer backs the primary array and catches lines that a conflict pushed out. Each primary line and each victim entry holds a valid bit, a tag and a physical line base.

A lookup that hits in either structure is answered combinationally, in the cycle of the request. A lookup that misses both raises a refill request toward the translation side and makes the block busy. The block stays busy until a refill response arrives. A good response installs the new line and moves the line it displaces into the victim buffer. A faulting response changes nothing. A global invalidate empties both structures. Five counters record the outcome of every accepted lookup.

Top module: `fetch_line_cache`

## Requirements
- R1: The fetch address is split into offset `reqAddr[7:0]`, index `reqAddr[15:8]` and tag `reqAddr[31:16]`. A primary hit needs the indexed line to be valid and its stored tag to equal the address tag. On a hit, `rspAddr` is `{stored line base, offset}`.
- R2: A lookup is accepted when `reqValid` is high, `busy` is low and `invalidate` is low. A primary hit raises `rspHit` in the same cycle as the request.
- R3: On a primary miss, every victim entry is compared against the key `reqAddr[31:8]`, and only valid entries can match. On a victim hit, `rspHit` is high in the same cycle and `rspAddr` is `{victim base, offset}`. If several entries match, the lowest-numbered entry wins.
- R4: A victim hit swaps the victim entry with the indexed primary line. The primary line takes the address tag. The victim entry takes the key `{old primary tag, index}` and the old primary valid bit. After a swap, a fetch to the displaced line's address hits in the victim buffer.
- R5: When a lookup misses both structures, `rspHit` is low. From the next cycle `busy` and `refillReq` are high, and `refillVaddr` holds the missed address. While busy, no lookup is accepted: `rspHit` stays low and no counter moves. `busy` falls in the cycle after `refillDone` is seen.
- R6: A refill with `refillFault` low writes the indexed primary line with the new tag, valid set and line base `{refillPpn, refillVaddr[11:8]}`. If that line was valid before, its contents first go to the victim slot named by a round-robin pointer, under the key `{tag, index}`. The pointer then advances modulo 16 and overwrites whatever the slot held.
- R7: A refill with `refillFault` high leaves both structures and the pointer unchanged, and `busy` still falls.
- R8: `invalidate` clears every primary line, every victim entry and the pointer. A request in the same cycle is not accepted.
- R9: Counters `cntFetch`, `cntPriHit`, `cntPriMiss`, `cntVicHit` and `cntVicMiss` each increment by one per accepted lookup of their kind. A victim hit or victim miss is counted only after a primary miss.
- R10: After reset, all valid bits, the pointer and all counters are zero, and `busy` and `refillReq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| invalidate | input | 1 | Global flush of both structures |
| reqValid | input | 1 | Fetch lookup request |
| reqAddr | input | 32 | Virtual fetch address |
| rspHit | output | 1 | Lookup accepted and hit (primary or victim) |
| rspAddr | output | 32 | Physical byte address on a hit |
| busy | output | 1 | Refill outstanding, no lookup accepted |
| refillReq | output | 1 | Translation request toward the refill side |
| refillVaddr | output | 32 | Address that missed |
| refillDone | input | 1 | Refill response strobe |
| refillFault | input | 1 | Refill response carries a fault |
| refillPpn | input | 20 | Translated physical page number |
| cntFetch | output | 32 | Accepted lookups |
| cntPriHit | output | 32 | Primary hits |
| cntPriMiss | output | 32 | Primary misses |
| cntVicHit | output | 32 | Victim hits |
| cntVicMiss | output | 32 | Victim misses |

## Verification
Directed sequences cover distinct situations: the same line refetched at a new offset, two tags fighting over one index, and a single index hammered with eighteen distinct tags. The first separates primary hits from misses. The second separates victim swaps from primary hits in both directions. The third tells pointer wraparound apart from retention. Faulting refills, requests held high during busy, and a request that coincides with invalidate show whether these cases leave state and counters alone. Random fetches over a handful of indices and tags, with occasional faults and flushes, then mix every path. A bench model of both arrays predicts each response and the counters.

// File: rtl/fcl_pkg.sv
package fcl_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic swapVictim;
    logic capturePend;
    logic install;
  } fcl_strobe_t;

  localparam int CntFetch   = 0;
  localparam int CntPriHit  = 1;
  localparam int CntPriMiss = 2;
  localparam int CntVicHit  = 3;
  localparam int CntVicMiss = 4;
  localparam int CntNum     = 5;
endpackage

// File: rtl/fcl_datapath.sv
module fcl_datapath
  import fcl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 8,
  parameter int IDX_W  = 8,
  parameter int VIC_N  = 16,
  parameter int PAGE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  fcl_strobe_t       stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-PAGE_W-1:0] refillPpn,
  output logic              priHit,
  output logic              vicHit,
  output logic [ADDR_W-1:0] hitAddr,
  output logic [ADDR_W-1:0] pendAddr
);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int KEY_W  = TAG_W + IDX_W;
  localparam int BASE_W = ADDR_W - OFF_W;
  localparam int LINES  = 1 << IDX_W;
  localparam int PTR_W  = $clog2(VIC_N);

  logic              priValid [LINES];
  logic [TAG_W-1:0]  priTag   [LINES];
  logic [BASE_W-1:0] priBase  [LINES];
  logic              vicValid [VIC_N];
  logic [KEY_W-1:0]  vicKey   [VIC_N];
  logic [BASE_W-1:0] vicBase  [VIC_N];
  logic [PTR_W-1:0]  vicPtr;

  // lookup fields
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic [KEY_W-1:0] key;
  logic [PTR_W-1:0] vicSel;
  assign idx = reqAddr[OFF_W +: IDX_W];
  assign tag = reqAddr[ADDR_W-1 -: TAG_W];
  assign key = reqAddr[ADDR_W-1:OFF_W];

  assign priHit = priValid[idx] && (priTag[idx] == tag);

  // lowest matching victim entry wins
  always_comb begin
    vicSel = '0;
    vicHit = 1'b0;
    for (int j = VIC_N - 1; j >= 0; j--) begin
      if (vicValid[j] && (vicKey[j] == key)) begin
        vicSel = PTR_W'(j);
        vicHit = 1'b1;
      end
    end
  end

  assign hitAddr = {(priHit ? priBase[idx] : vicBase[vicSel]), reqAddr[OFF_W-1:0]};

  // refill fields
  logic [IDX_W-1:0]  pIdx;
  logic [TAG_W-1:0]  pTag;
  logic [BASE_W-1:0] newBase;
  logic [PTR_W-1:0]  ptrNext;
  assign pIdx    = pendAddr[OFF_W +: IDX_W];
  assign pTag    = pendAddr[ADDR_W-1 -: TAG_W];
  assign newBase = {refillPpn, pendAddr[PAGE_W-1:OFF_W]};
  assign ptrNext = (vicPtr == PTR_W'(VIC_N - 1)) ? '0 : vicPtr + 1'b1;

  // valid bits, pointer, pending address
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) priValid[i] <= 1'b0;
      for (int j = 0; j < VIC_N; j++) vicValid[j] <= 1'b0;
      vicPtr   <= '0;
      pendAddr <= '0;
    end else begin
      if (stb.capturePend) pendAddr <= reqAddr;
      if (stb.clearAll) begin
        for (int i = 0; i < LINES; i++) priValid[i] <= 1'b0;
        for (int j = 0; j < VIC_N; j++) vicValid[j] <= 1'b0;
        vicPtr <= '0;
      end else if (stb.swapVictim) begin
        priValid[idx]    <= vicValid[vicSel];
        vicValid[vicSel] <= priValid[idx];
      end else if (stb.install) begin
        if (priValid[pIdx]) begin
          vicValid[vicPtr] <= 1'b1;
          vicPtr           <= ptrNext;
        end
        priValid[pIdx] <= 1'b1;
      end
    end
  end

  // tags and bases carry no reset
  always_ff @(posedge clk) begin
    if (stb.swapVictim) begin
      priTag[idx]     <= tag;
      priBase[idx]    <= vicBase[vicSel];
      vicKey[vicSel]  <= {priTag[idx], idx};
      vicBase[vicSel] <= priBase[idx];
    end else if (stb.install) begin
      if (priValid[pIdx]) begin
        vicKey[vicPtr]  <= {priTag[pIdx], pIdx};
        vicBase[vicPtr] <= priBase[pIdx];
      end
      priTag[pIdx]  <= pTag;
      priBase[pIdx] <= newBase;
    end
  end
endmodule

// File: rtl/fcl_control.sv
module fcl_control
  import fcl_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        invalidate,
  input  logic        reqValid,
  input  logic        refillDone,
  input  logic        refillFault,
  input  logic        priHit,
  input  logic        vicHit,
  output fcl_strobe_t stb,
  output logic        busy,
  output logic        rspHit,
  output logic [CNT_W-1:0] cntOut [CntNum]
);
  logic accept;
  logic [CntNum-1:0] inc;

  assign accept = reqValid && !busy && !invalidate;
  assign rspHit = accept && (priHit || vicHit);

  always_comb begin
    stb.clearAll    = invalidate;
    stb.swapVictim  = accept && !priHit && vicHit;
    stb.capturePend = accept && !priHit && !vicHit;
    stb.install     = busy && refillDone && !refillFault && !invalidate;
  end

  always_comb begin
    inc             = '0;
    inc[CntFetch]   = accept;
    inc[CntPriHit]  = accept && priHit;
    inc[CntPriMiss] = accept && !priHit;
    inc[CntVicHit]  = stb.swapVictim;
    inc[CntVicMiss] = stb.capturePend;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      for (int k = 0; k < CntNum; k++) cntOut[k] <= '0;
    end else begin
      if (stb.capturePend) busy <= 1'b1;
      else if (busy && refillDone) busy <= 1'b0;
      for (int k = 0; k < CntNum; k++)
        if (inc[k]) cntOut[k] <= cntOut[k] + 1'b1;
    end
  end
endmodule

// File: rtl/fetch_line_cache.sv
module fetch_line_cache
  import fcl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 8,
  parameter int IDX_W  = 8,
  parameter int VIC_N  = 16,
  parameter int PAGE_W = 12,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              invalidate,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspHit,
  output logic [ADDR_W-1:0] rspAddr,
  output logic              busy,
  output logic              refillReq,
  output logic [ADDR_W-1:0] refillVaddr,
  input  logic              refillDone,
  input  logic              refillFault,
  input  logic [ADDR_W-PAGE_W-1:0] refillPpn,
  output logic [CNT_W-1:0]  cntFetch,
  output logic [CNT_W-1:0]  cntPriHit,
  output logic [CNT_W-1:0]  cntPriMiss,
  output logic [CNT_W-1:0]  cntVicHit,
  output logic [CNT_W-1:0]  cntVicMiss
);
  fcl_strobe_t stb;
  logic priHit, vicHit;
  logic [CNT_W-1:0] cnt [CntNum];

  fcl_control #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .invalidate(invalidate), .reqValid(reqValid),
    .refillDone(refillDone), .refillFault(refillFault),
    .priHit(priHit), .vicHit(vicHit), .stb(stb), .busy(busy),
    .rspHit(rspHit), .cntOut(cnt)
  );

  fcl_datapath #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
                 .VIC_N(VIC_N), .PAGE_W(PAGE_W)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr),
    .refillPpn(refillPpn), .priHit(priHit), .vicHit(vicHit),
    .hitAddr(rspAddr), .pendAddr(refillVaddr)
  );

  assign refillReq  = busy;
  assign cntFetch   = cnt[CntFetch];
  assign cntPriHit  = cnt[CntPriHit];
  assign cntPriMiss = cnt[CntPriMiss];
  assign cntVicHit  = cnt[CntVicHit];
  assign cntVicMiss = cnt[CntVicMiss];
endmodule

// File: rtl/fcl_checker.sv
module fcl_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             invalidate,
  input logic             reqValid,
  input logic             rspHit,
  input logic             busy,
  input logic             refillDone,
  input logic [CNT_W-1:0] cntFetch,
  input logic [CNT_W-1:0] cntPriHit,
  input logic [CNT_W-1:0] cntPriMiss,
  input logic [CNT_W-1:0] cntVicHit,
  input logic [CNT_W-1:0] cntVicMiss
);
  // R5: no hit reported while a refill is outstanding
  a_r5_busy_no_hit: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !rspHit);

  // R5: an accepted full miss makes the block busy next cycle
  a_r5_miss_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && !invalidate && !rspHit) |=> busy);

  // R5: refill response ends busy
  a_r5_done_clears_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && refillDone) |=> !busy);

  // R2: a hit is only reported for a present request
  a_r2_hit_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> (reqValid && !invalidate));

  // R9: primary outcomes sum to fetches, victim outcomes to primary misses
  a_r9_primary_sum: assert property (@(posedge clk) disable iff (!rstN)
    (cntPriHit + cntPriMiss) == cntFetch);
  a_r9_victim_sum: assert property (@(posedge clk) disable iff (!rstN)
    (cntVicHit + cntVicMiss) == cntPriMiss);

  // R9: fetch counter steps by one per accepted lookup
  a_r9_fetch_step: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && !invalidate) |=> cntFetch == $past(cntFetch) + 1'b1);

  // R5: busy holds fetch counter
  a_r5_busy_hold_cnt: assert property (@(posedge clk) disable iff (!rstN)
    (busy || invalidate) |=> $stable(cntFetch));
endmodule

bind fetch_line_cache fcl_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .invalidate(invalidate), .reqValid(reqValid),
  .rspHit(rspHit), .busy(busy), .refillDone(refillDone),
  .cntFetch(cntFetch), .cntPriHit(cntPriHit), .cntPriMiss(cntPriMiss),
  .cntVicHit(cntVicHit), .cntVicMiss(cntVicMiss)
);

// File: tb/tb_fetch_line_cache.sv
`timescale 1ns/1ps
module tb_fetch_line_cache;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic invalidate = 1'b0, reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic rspHit, busy, refillReq;
  logic [31:0] rspAddr, refillVaddr;
  logic refillDone = 1'b0, refillFault = 1'b0;
  logic [19:0] refillPpn = '0;
  logic [31:0] cntFetch, cntPriHit, cntPriMiss, cntVicHit, cntVicMiss;

  always #2.5 clk = ~clk;

  fetch_line_cache dut (
    .clk(clk), .rstN(rstN), .invalidate(invalidate), .reqValid(reqValid),
    .reqAddr(reqAddr), .rspHit(rspHit), .rspAddr(rspAddr), .busy(busy),
    .refillReq(refillReq), .refillVaddr(refillVaddr), .refillDone(refillDone),
    .refillFault(refillFault), .refillPpn(refillPpn), .cntFetch(cntFetch),
    .cntPriHit(cntPriHit), .cntPriMiss(cntPriMiss), .cntVicHit(cntVicHit),
    .cntVicMiss(cntVicMiss)
  );

  // reference model
  bit          mPV [256];
  logic [15:0] mPT [256];
  logic [23:0] mPB [256];
  bit          mVV [16];
  logic [23:0] mVK [16];
  logic [23:0] mVB [16];
  int mPtr = 0;
  logic [31:0] mFetch = 0, mPH = 0, mPM = 0, mVH = 0, mVM = 0;
  int nChecks = 0, nFail = 0;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [19:0] ppnOf(input logic [19:0] v);
    return {v[9:0], v[19:10]} ^ 20'h5A3C1;
  endfunction

  task automatic modelClear();
    for (int i = 0; i < 256; i++) mPV[i] = 0;
    for (int j = 0; j < 16; j++) mVV[j] = 0;
    mPtr = 0;
  endtask

  task automatic chkCounters(input string rq);
    chk({rq, " R9 cntFetch"},   cntFetch,   mFetch);
    chk({rq, " R9 cntPriHit"},  cntPriHit,  mPH);
    chk({rq, " R9 cntPriMiss"}, cntPriMiss, mPM);
    chk({rq, " R9 cntVicHit"},  cntVicHit,  mVH);
    chk({rq, " R9 cntVicMiss"}, cntVicMiss, mVM);
  endtask

  task automatic doFetch(input logic [31:0] a, input bit fault, input string rq);
    logic [7:0]  idx = a[15:8];
    logic [15:0] tg  = a[31:16];
    logic [23:0] key = a[31:8];
    int vs = -1;
    bit ph;
    bit tV; logic [15:0] tT; logic [23:0] tB;
    logic [19:0] ppn;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a;
    #1;
    ph = mPV[idx] && (mPT[idx] == tg);
    for (int j = 15; j >= 0; j--) if (mVV[j] && mVK[j] == key) vs = j;
    mFetch++;
    if (ph) begin
      mPH++;
      chk({rq, " R2 primary hit"}, rspHit, 1);
      chk({rq, " R1 primary addr"}, rspAddr, {mPB[idx], a[7:0]});
      @(negedge clk); reqValid = 1'b0;
    end else if (vs >= 0) begin
      mPM++; mVH++;
      chk({rq, " R3 victim hit"}, rspHit, 1);
      chk({rq, " R4 victim addr"}, rspAddr, {mVB[vs], a[7:0]});
      tV = mPV[idx]; tT = mPT[idx]; tB = mPB[idx];
      mPV[idx] = 1; mPT[idx] = tg; mPB[idx] = mVB[vs];
      mVV[vs] = tV; mVK[vs] = {tT, idx}; mVB[vs] = tB;
      @(negedge clk); reqValid = 1'b0;
    end else begin
      mPM++; mVM++;
      chk({rq, " R5 miss no hit"}, rspHit, 0);
      @(negedge clk);
      #1;
      chk({rq, " R5 busy"}, busy, 1);
      chk({rq, " R5 refillReq"}, refillReq, 1);
      chk({rq, " R5 refillVaddr"}, refillVaddr, a);
      chk({rq, " R5 no hit while busy"}, rspHit, 0);
      repeat (2) @(negedge clk);
      ppn = ppnOf(a[31:12]);
      refillDone = 1'b1; refillFault = fault; refillPpn = ppn;
      @(negedge clk);
      refillDone = 1'b0; refillFault = 1'b0; reqValid = 1'b0;
      #1;
      chk({rq, fault ? " R7 busy drops" : " R5 busy drops"}, busy, 0);
      if (!fault) begin
        if (mPV[idx]) begin
          mVV[mPtr] = 1; mVK[mPtr] = {mPT[idx], idx}; mVB[mPtr] = mPB[idx];
          mPtr = (mPtr + 1) % 16;
        end
        mPV[idx] = 1; mPT[idx] = tg; mPB[idx] = {ppn, a[11:8]};
      end
    end
  endtask

  task automatic doInvalidate(input logic [31:0] a);
    @(negedge clk);
    invalidate = 1'b1; reqValid = 1'b1; reqAddr = a;
    #1;
    chk("R8 request during invalidate", rspHit, 0);
    @(negedge clk);
    invalidate = 1'b0; reqValid = 1'b0;
    modelClear();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    modelClear();
    repeat (3) @(negedge clk);
    chk("R10 busy after reset", busy, 0);
    chk("R10 refillReq after reset", refillReq, 0);
    chkCounters("R10");
    rstN = 1'b1;
    @(negedge clk);

    // R1/R6: cold miss, install, hit at another offset
    doFetch(32'h1234_5678, 0, "R6 cold");
    doFetch(32'h1234_56A4, 0, "R1 refetch");
    // R3/R4: conflict at index 0x56, then swaps both ways
    doFetch(32'hABCD_5610, 0, "R6 conflict");
    doFetch(32'h1234_5600, 0, "R4 swap in");
    doFetch(32'hABCD_5620, 0, "R4 swap back");
    doFetch(32'hABCD_5624, 0, "R2 after swap");
    // R7: faulting refill at the same index leaves state
    doFetch(32'h7777_5600, 1, "R7 fault");
    doFetch(32'hABCD_5628, 0, "R7 primary kept");
    doFetch(32'h1234_5604, 0, "R7 victim kept");
    doFetch(32'h7777_5600, 0, "R7 retry");
    chkCounters("R9 directed");
    // R6: pointer wrap at one index
    for (int t = 1; t <= 18; t++) doFetch({16'(t) , 8'h20, 8'h00}, 0, "R6 wrap fill");
    doFetch({16'd1, 8'h20, 8'h40}, 0, "R6 overwritten slot");
    doFetch({16'd17, 8'h20, 8'h40}, 0, "R6 retained slot");
    // R8: invalidate empties everything
    doInvalidate(32'h1234_5600);
    doFetch(32'hABCD_5600, 0, "R8 after invalidate");
    doFetch({16'd17, 8'h20, 8'h44}, 0, "R8 victim cleared");
    chkCounters("R9 after flush");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [7:0] ix;
      logic [31:0] a;
      case ($urandom % 3)
        0: ix = 8'h56;
        1: ix = 8'h57;
        default: ix = 8'h20;
      endcase
      a = {16'($urandom % 6), ix, 8'($urandom) & 8'hFC};
      if (($urandom % 50) == 0) doInvalidate(a);
      doFetch(a, ($urandom % 8) == 0, "rand");
    end
    chkCounters("R9 final");

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule